// File: doc/BRIEF.md
# Tracking Converter Step Controller

This block is the digital loop of a tracking analog-to-digital converter. It holds a code that drives an external DAC. An external comparator reports whether the analog input lies above the DAC output. On every enabled clock the block moves the code one step toward the input. As a result, the DAC output follows the analog signal, and the code is the conversion result.

The code rises while the comparator reports the input above the DAC level. It falls otherwise. It never wraps past either end of the range. The DAC output is at the low reference at code 0 and one LSB short of the high reference at code 2^N-1. Because each update moves only one LSB, a full-range jump needs up to 2^N-1 enabled cycles. Once the code settles, the comparator answer flips on every update, and the block raises a lock flag.

Top module: `track_adc_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `code` to mid-scale, 2^(N-1), and clears `locked`. The first enabled update after reset never sets `locked`.
- R2: On an edge with `en` high, `cmp_above` high and `code` below 2^N-1, `code` increases by exactly one.
- R3: On an edge with `en` high, `cmp_above` low and `code` above 0, `code` decreases by exactly one.
- R4: With `en` high and `cmp_above` high, a `code` of 2^N-1 stays at 2^N-1 and does not wrap.
- R5: With `en` high and `cmp_above` low, a `code` of 0 stays at 0 and does not wrap.
- R6: On an edge with `en` low, both `code` and `locked` keep their values, whatever `cmp_above` does.
- R7: After each enabled update, `locked` is 1 if the `cmp_above` value of that update differs from the value seen at the previous enabled update. Otherwise `locked` is 0.
- R8: For a constant input strictly between two adjacent DAC levels, the loop ends up with `locked` high and `code` alternating between those two codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Update enable. When low, all state holds |
| cmp_above | input | 1 | Comparator result: 1 when the analog input is above the DAC output |
| code | output | N | Code driving the DAC; also the conversion result |
| locked | output | 1 | High while the comparator answer alternates between updates |

## Verification
The embedded assertions check the reset value, the single-step moves up and down, saturation at both ends, and the hold while disabled on every cycle. The lock flag's dependence on the previous update, and the settling into a one-LSB dither around an input, only show up across whole scenarios. A behavioural DAC-and-comparator model in the bench closes the loop for those. The scenarios cover inputs between levels, an input exactly on a level, inputs beyond both rails, enable gaps, and a reset during tracking.

// File: rtl/track_adc_ctrl.sv
module track_adc_ctrl #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         cmp_above,
  output logic [N-1:0] code,
  output logic         locked
);
  localparam logic [N-1:0] TOP = {N{1'b1}};
  localparam logic [N-1:0] MID = {1'b1, {(N-1){1'b0}}};

  logic last_dir;
  logic seen;

  wire at_top = (code == TOP);
  wire at_bot = (code == '0);
  wire [N-1:0] next_code = cmp_above ? (at_top ? code : code + 1'b1)
                                     : (at_bot ? code : code - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      code     <= MID;
      last_dir <= 1'b0;
      seen     <= 1'b0;
      locked   <= 1'b0;
    end else if (en) begin
      code     <= next_code;
      last_dir <= cmp_above;
      seen     <= 1'b1;
      locked   <= seen && (cmp_above != last_dir);
    end
  end

  p_reset_mid_r1: assert property (@(posedge clk)
    rst |=> (code == MID) && !locked);

  p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
    (en && cmp_above && code != TOP) |=> code == $past(code) + 1'b1);

  p_step_down_r3: assert property (@(posedge clk) disable iff (rst)
    (en && !cmp_above && code != '0) |=> code == $past(code) - 1'b1);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (en && cmp_above && code == TOP) |=> code == TOP);

  p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    (en && !cmp_above && code == '0) |=> code == '0);

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(code) && $stable(locked));

  p_first_update_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && en) |=> !locked);
endmodule

// File: tb/sim_track_adc_ctrl.sv
module sim_track_adc_ctrl;
  localparam int N   = 8;
  localparam int TOP = (1 << N) - 1;
  localparam int MID = 1 << (N - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic cmp_above = 1'b0;
  logic [N-1:0] code;
  logic locked;

  int checks = 0;
  int errors = 0;
  int m_code = MID;
  int m_prev = 0;
  int m_seen = 0;
  int m_lock = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  track_adc_ctrl #(.N(N)) u0 (
    .clk(clk), .rst(rst), .en(en), .cmp_above(cmp_above),
    .code(code), .locked(locked)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // ain is the analog input in quarter-LSB units; DAC level of code k is 4*k
  task automatic cyc(input bit r, input bit e, input int ain);
    string ctag;
    string ltag;
    bit c;
    c = (ain > 4 * m_code);
    rst = r; en = e; cmp_above = c;
    if (r) begin
      m_code = MID; m_prev = 0; m_seen = 0; m_lock = 0;
      ctag = "R1"; ltag = "R1";
    end else if (e) begin
      m_lock = (m_seen != 0) && (int'(c) != m_prev);
      m_prev = c; m_seen = 1;
      ltag = "R7";
      if (c) begin
        if (m_code == TOP) ctag = "R4";
        else begin m_code++; ctag = "R2"; end
      end else begin
        if (m_code == 0) ctag = "R5";
        else begin m_code--; ctag = "R3"; end
      end
    end else begin
      ctag = "R6"; ltag = "R6";
    end
    @(posedge clk);
    @(negedge clk);
    check(ctag, int'(code), m_code);
    check(ltag, int'(locked), m_lock);
  endtask

  task automatic run(input int n, input int ain);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, ain);
  endtask

  task automatic dither_check(input int lo);
    int a, b;
    a = int'(code);
    cyc(1'b0, 1'b1, 4 * lo + 2);
    b = int'(code);
    check("R8", int'(locked), 1);
    check("R8", (a == lo || a == lo + 1) ? 1 : 0, 1);
    check("R8", (a != b) ? 1 : 0, 1);
  endtask

  initial begin
    @(negedge clk);
    // R1: reset state
    cyc(1'b1, 1'b0, 0);
    cyc(1'b1, 1'b1, 0);
    check("R1", int'(code), MID);
    check("R1", int'(locked), 0);
    // R1: the first update after reset does not lock
    cyc(1'b0, 1'b1, 0);
    check("R1", int'(locked), 0);
    // R2/R8: climb to 200.5 LSB
    run(150, 4 * 200 + 2);
    dither_check(200);
    // R6: disabled while the input moves
    for (int i = 0; i < 12; i++) cyc(1'b0, 1'b0, (i % 2) ? 0 : 4000);
    // R3/R8: fall to 10.5 LSB
    run(250, 4 * 10 + 2);
    dither_check(10);
    // R4: input above full scale
    run(300, 4 * 300);
    check("R4", int'(code), TOP);
    check("R7", int'(locked), 0);
    // R5: input below low reference
    run(300, -4);
    check("R5", int'(code), 0);
    // R7: input exactly on level 50 dithers between 49 and 50
    run(120, 4 * 50);
    check("R7", int'(locked), 1);
    // R6/R7: sparse enable while tracking
    for (int i = 0; i < 200; i++) cyc(1'b0, (i % 3) == 0, 4 * 90 + 1);
    // R1: reset in the middle of tracking
    cyc(1'b1, 1'b1, 4 * 90 + 1);
    check("R1", int'(code), MID);
    check("R1", int'(locked), 0);
    run(60, 4 * 100 + 3);
    dither_check(100);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule